// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames from a streaming input and places each one into host memory through a circular ring of 32-byte receive descriptors. When the first beat of a frame is offered, the block reads the descriptor at its current ring position. If software has handed that descriptor to hardware, the block reads the descriptor's buffer address and stores the frame there one 32-bit word at a time. It then writes back the frame's length and classification status and sets the owner bit, which returns the descriptor to software. One cycle after that, it pulses a receive-complete interrupt.

If the descriptor at the ring position still belongs to software, the whole frame is consumed and discarded, and a drop counter counts it. Software can stop new claims with a suspend input or a poll-enable input, and can move the ring position back to the base address with a one-cycle clear pulse. Checksum results, protocol class, source port and the tag flags come in as sideband inputs, which are sampled on the last beat of the frame.

Descriptor layout as seen from the memory port: word 0 at offset 0 holds the buffer address. Control word 1 at offset 4 holds the following fields:
- [15:0] buffer size on entry, received length on write-back
- 16: L4 checksum failure
- 17: IP checksum failure
- [21:18] protocol code
- [27:22] header field, written as 0
- 28: last segment
- 29: first segment
- 30: end of ring
- 31: owner, where 0 means hardware and 1 means software

Control word 2 at offset 8 holds the tag flags in [1:0], the source port in [10:8] and the CRC error in 11.

Top module: `rx_desc_writer`

## Requirements
- R1: While reset is asserted and after it is released with no frame offered, s_tready, mem_req and rx_irq are 0 and drop_count is 0. The first claim after reset uses ctl_ring_base.
- R2: With ctl_poll_en=1 and ctl_suspend=0, an offered frame makes the block read control word 1 (offset 4) of the current descriptor. If bit 31 of that word is 0, the block reads the buffer address (offset 0) and writes beat k of the frame to buffer address + 4k.
- R3: The write-back of control word 1 holds the following values:
  - [15:0]: the received length in bytes, which is the sum of the set s_tkeep bits over all beats
  - bit 16: s_l4_fail
  - bit 17: s_ip_fail
  - [21:18]: s_proto
  - [27:22]: 0
  - bits 28 and 29: 1
  - bit 30: the end-of-ring bit that software wrote
  - bit 31: 1
- R4: The write-back of control word 2 holds s_vtag in [1:0], s_src_port in [10:8] and the CRC flag in bit 11. Every other bit is 0. The sideband values are those of the frame's last beat.
- R5: Control word 2 is written in the cycle just before control word 1. rx_irq is high for exactly one cycle, in the cycle after the write of control word 1, and it pulses once per descriptor handed back.
- R6: When irq_mask is 1 in the cycle that control word 1 is written, rx_irq stays 0, but the data and status write-back still take place.
- R7: After each descriptor is handed back, the ring position advances by 32 bytes. If the end-of-ring bit of that descriptor was 1, the ring position wraps to ctl_ring_base instead.
- R8: If bit 31 of control word 1 is 1 when the frame is claimed, the block accepts every beat of the frame, writes nothing to memory, does not pulse rx_irq, adds one to drop_count on the last beat, and keeps its ring position.
- R9: A frame longer than the buffer size is truncated as follows:
  - only words whose byte offset is below the size are written
  - the written-back length equals the size
  - bit 11 of control word 2 is set
- R10: While ctl_suspend=1 or ctl_poll_en=0, no claim starts. s_tready stays 0 and the frame is held. The frame is stored normally once claims are allowed again.
- R11: A one-cycle pulse on ctl_clr_state while the block is idle sets the ring position to ctl_ring_base.
- R12: s_crc_err=1 on the last beat sets bit 11 of control word 2 even when the frame fits in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tdata | input | 32 | Stream data word |
| s_tkeep | input | 4 | Byte enables of the beat, contiguous from bit 0 |
| s_tlast | input | 1 | Last beat of the frame |
| s_src_port | input | 3 | Source port of the frame |
| s_proto | input | 4 | Protocol class code |
| s_l4_fail | input | 1 | L4 checksum failed |
| s_ip_fail | input | 1 | IP checksum failed |
| s_crc_err | input | 1 | Frame CRC error |
| s_vtag | input | 2 | Tag flags |
| ctl_poll_en | input | 1 | Allows descriptor claims |
| ctl_suspend | input | 1 | Stops descriptor claims |
| ctl_clr_state | input | 1 | Moves the ring position to the base |
| ctl_ring_base | input | ADDR_W | Byte address of the first descriptor |
| irq_mask | input | 1 | Suppresses rx_irq |
| mem_req | output | 1 | Memory access request, always accepted |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_irq | output | 1 | Receive-complete pulse |
| drop_count | output | DROP_W | Number of frames dropped |

## Verification
On every cycle, the assertions check the following:
- the ring position steps by one descriptor, wraps to the base, or holds, as its controls demand
- no claim starts while claims are stopped
- no memory access happens during a drop
- data writes stay inside the claimed buffer
- control word 2 is written immediately before control word 1
- the interrupt pulse is single and is withheld under the mask
- drop_count moves only on an accepted last beat

Only the bench's scenarios can show the rest:
- that the stored words, lengths and status fields hold the right values
- that the ring wraps at the marked descriptor
- that a ring filled by earlier frames drops the next frame
- that a recycled descriptor is reused in order
- that a held frame completes after a suspend

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int unsigned LEN_W      = 16;
  localparam int unsigned DESC_BYTES = 32;
  localparam int unsigned OFS_BUF    = 0;
  localparam int unsigned OFS_CW1    = 4;
  localparam int unsigned OFS_CW2    = 8;
  localparam int unsigned B_OWN      = 31;
  localparam int unsigned B_EOR      = 30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDCTL, ST_CHKCTL, ST_CHKPTR,
    ST_DATA, ST_DROP, ST_WB2, ST_WB1
  } rxr_state_e;

  typedef struct packed {
    logic [2:0] port;
    logic [3:0] proto;
    logic       l4_fail;
    logic       ip_fail;
    logic       crc_err;
    logic [1:0] vtag;
  } rxr_side_t;

  function automatic logic [31:0] pack_cw1(input logic eor, input rxr_side_t sd,
                                           input logic [LEN_W-1:0] len);
    return {1'b1, eor, 1'b1, 1'b1, 6'b0, sd.proto, sd.ip_fail, sd.l4_fail, len};
  endfunction

  function automatic logic [31:0] pack_cw2(input rxr_side_t sd, input logic trunc);
    logic [31:0] w;
    w        = '0;
    w[1:0]   = sd.vtag;
    w[10:8]  = sd.port;
    w[11]    = sd.crc_err | trunc;
    return w;
  endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
  import rxr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur_ptr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              init_q, init_d;
  logic              load;
  logic              cur_en;

  assign load = clr | init_q;

  always_comb begin
    cur_d  = cur_q;
    cur_en = 1'b0;
    init_d = 1'b0;
    if (load) begin
      cur_d  = base;
      cur_en = 1'b1;
    end else if (advance) begin
      cur_d  = wrap ? base : (cur_q + STEP);
      cur_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      init_q <= 1'b1;
    end else begin
      init_q <= init_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign cur_ptr = cur_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(advance && !wrap && !load) |-> cur_q == $past(cur_q) + STEP); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(advance && wrap && !load) |-> cur_q == $past(base)); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> cur_q == $past(base)); // R11
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!advance && !load) |-> $stable(cur_q)); // R8

endmodule

// File: rtl/rxr_frame_acc.sv
module rxr_frame_acc
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic [3:0]       keep,
  input  logic [LEN_W-1:0] buf_size,
  output logic             in_buf,
  output logic [LEN_W-1:0] word_idx,
  output logic [LEN_W-1:0] frame_len,
  output logic             trunc
);

  localparam int unsigned CW = LEN_W + 1;
  localparam logic [CW-1:0]    CNT_MAX = '1;
  localparam logic [LEN_W-1:0] IDX_MAX = '1;

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic             acc_en;
  logic [CW:0]      sum;

  assign sum = {1'b0, cnt_q} + (CW+1)'($countones(keep));

  always_comb begin
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    acc_en = 1'b0;
    if (start) begin
      cnt_d  = '0;
      idx_d  = '0;
      acc_en = 1'b1;
    end else if (beat) begin
      cnt_d  = sum[CW] ? CNT_MAX : sum[CW-1:0];
      idx_d  = (idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1;
      acc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (acc_en) begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign in_buf    = {idx_q, 2'b00} < {2'b00, buf_size};
  assign word_idx  = idx_q;
  assign trunc     = cnt_q > {1'b0, buf_size};
  assign frame_len = trunc ? buf_size : cnt_q[LEN_W-1:0];

  AST_CNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(beat && !start) |-> cnt_q >= $past(cnt_q)); // R3

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  input  logic [31:0]       s_tdata,
  input  rxr_side_t         side_in,
  output logic              s_tready,
  output logic              beat,
  input  logic              poll_en,
  input  logic              suspend,
  input  logic              clr_state,
  input  logic              irq_mask,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic              in_buf,
  input  logic [LEN_W-1:0]  word_idx,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              trunc,
  output logic [LEN_W-1:0]  buf_size,
  output logic              acc_start,
  output logic              advance,
  output logic              wrap,
  output logic              drop_inc,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  rxr_state_e        state_q, state_d;
  logic [LEN_W-1:0]  size_q;
  logic              eor_q;
  logic [ADDR_W-1:0] bptr_q;
  rxr_side_t         side_q;
  logic              irq_q, irq_d;
  logic              ctl_en, ptr_en, side_en;

  assign s_tready = (state_q == ST_DATA) || (state_q == ST_DROP);
  assign beat     = s_tvalid && s_tready;

  always_comb begin
    state_d   = state_q;
    ctl_en    = 1'b0;
    ptr_en    = 1'b0;
    side_en   = 1'b0;
    acc_start = 1'b0;
    advance   = 1'b0;
    drop_inc  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (s_tvalid && poll_en && !suspend && !clr_state) state_d = ST_RDCTL;
      end
      ST_RDCTL: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'(OFS_CW1);
        state_d  = ST_CHKCTL;
      end
      ST_CHKCTL: begin
        ctl_en = 1'b1;
        if (mem_rdata[B_OWN]) begin
          state_d = ST_DROP;
        end else begin
          mem_req  = 1'b1;
          mem_addr = cur_ptr + ADDR_W'(OFS_BUF);
          state_d  = ST_CHKPTR;
        end
      end
      ST_CHKPTR: begin
        ptr_en    = 1'b1;
        acc_start = 1'b1;
        state_d   = ST_DATA;
      end
      ST_DATA: begin
        if (beat) begin
          mem_req   = in_buf;
          mem_we    = in_buf;
          mem_addr  = bptr_q + ADDR_W'({word_idx, 2'b00});
          mem_wdata = s_tdata;
          if (s_tlast) begin
            side_en = 1'b1;
            state_d = ST_WB2;
          end
        end
      end
      ST_DROP: begin
        if (beat && s_tlast) begin
          drop_inc = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_WB2: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + ADDR_W'(OFS_CW2);
        mem_wdata = pack_cw2(side_q, trunc);
        state_d   = ST_WB1;
      end
      ST_WB1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + ADDR_W'(OFS_CW1);
        mem_wdata = pack_cw1(eor_q, side_q, frame_len);
        advance   = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    irq_d = (state_q == ST_WB1) && !irq_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      size_q  <= '0;
      eor_q   <= 1'b0;
      bptr_q  <= '0;
      side_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (ctl_en) begin
        size_q <= mem_rdata[LEN_W-1:0];
        eor_q  <= mem_rdata[B_EOR];
      end
      if (ptr_en)  bptr_q <= mem_rdata;
      if (side_en) side_q <= side_in;
    end
  end

  assign buf_size = size_q;
  assign wrap     = eor_q;
  assign irq      = irq_q;

  AST_NO_CLAIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && (suspend || !poll_en)) |=> state_q == ST_IDLE); // R10
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !mem_req); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R5
  AST_WB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB1) |-> $past(state_q == ST_WB2 && mem_req && mem_we)); // R5
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && mem_req) |-> (mem_addr - bptr_q) < ADDR_W'(size_q)); // R9

endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxr_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DROP_W        = 16,
  parameter bit          DROP_SATURATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [31:0]       s_tdata,
  input  logic [3:0]        s_tkeep,
  input  logic              s_tlast,
  input  logic [2:0]        s_src_port,
  input  logic [3:0]        s_proto,
  input  logic              s_l4_fail,
  input  logic              s_ip_fail,
  input  logic              s_crc_err,
  input  logic [1:0]        s_vtag,
  input  logic              ctl_poll_en,
  input  logic              ctl_suspend,
  input  logic              ctl_clr_state,
  input  logic [ADDR_W-1:0] ctl_ring_base,
  input  logic              irq_mask,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              rx_irq,
  output logic [DROP_W-1:0] drop_count
);

  rxr_side_t         side;
  logic [ADDR_W-1:0] cur_ptr;
  logic              beat, in_buf, trunc, acc_start, advance, wrap, drop_inc;
  logic [LEN_W-1:0]  word_idx, frame_len, buf_size;
  logic [DROP_W-1:0] drop_q, drop_d;

  assign side = '{port: s_src_port, proto: s_proto, l4_fail: s_l4_fail,
                  ip_fail: s_ip_fail, crc_err: s_crc_err, vtag: s_vtag};

  rxr_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ctl_clr_state), .base(ctl_ring_base),
    .advance(advance), .wrap(wrap), .cur_ptr(cur_ptr)
  );

  rxr_frame_acc u_acc (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .beat(beat), .keep(s_tkeep),
    .buf_size(buf_size), .in_buf(in_buf), .word_idx(word_idx),
    .frame_len(frame_len), .trunc(trunc)
  );

  rxr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tdata(s_tdata), .side_in(side), .s_tready(s_tready), .beat(beat),
    .poll_en(ctl_poll_en), .suspend(ctl_suspend), .clr_state(ctl_clr_state),
    .irq_mask(irq_mask), .cur_ptr(cur_ptr), .in_buf(in_buf),
    .word_idx(word_idx), .frame_len(frame_len), .trunc(trunc),
    .buf_size(buf_size), .acc_start(acc_start), .advance(advance),
    .wrap(wrap), .drop_inc(drop_inc), .irq(rx_irq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  generate
    if (DROP_SATURATE) begin : g_drop_sat
      always_comb begin
        drop_d = drop_q;
        if (drop_inc && (drop_q != {DROP_W{1'b1}})) drop_d = drop_q + 1'b1;
      end
    end else begin : g_drop_wrap
      always_comb begin
        drop_d = drop_q;
        if (drop_inc) drop_d = drop_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= '0;
    else if (drop_inc) drop_q <= drop_d;
  end

  assign drop_count = drop_q;

  AST_DROP_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(s_tvalid && s_tready && s_tlast)); // R8
  AST_IRQ_AFTER_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(mem_req && mem_we && mem_wdata[B_OWN])); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !$past(irq_mask)); // R6

endmodule

// File: tb/rx_desc_writer_test.sv
`timescale 1ns/1ps
module rx_desc_writer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_tvalid = 1'b0, s_tlast = 1'b0;
  logic        s_tready;
  logic [31:0] s_tdata = '0;
  logic [3:0]  s_tkeep = 4'hF;
  logic [2:0]  s_src_port = '0;
  logic [3:0]  s_proto = '0;
  logic        s_l4_fail = 1'b0, s_ip_fail = 1'b0, s_crc_err = 1'b0;
  logic [1:0]  s_vtag = '0;
  logic        ctl_poll_en = 1'b1, ctl_suspend = 1'b0, ctl_clr_state = 1'b0;
  logic [31:0] ctl_ring_base = 32'h0;
  logic        irq_mask = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rx_irq;
  logic [15:0] drop_count;

  logic [31:0] mem [0:255];
  int errors = 0, checks = 0;
  int cyc = 0, t_w1 = 0, t_w2 = 0, t_irq = 0, irq_cnt = 0, wr_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_desc_writer uut (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .s_src_port(s_src_port), .s_proto(s_proto), .s_l4_fail(s_l4_fail),
    .s_ip_fail(s_ip_fail), .s_crc_err(s_crc_err), .s_vtag(s_vtag),
    .ctl_poll_en(ctl_poll_en), .ctl_suspend(ctl_suspend),
    .ctl_clr_state(ctl_clr_state), .ctl_ring_base(ctl_ring_base),
    .irq_mask(irq_mask), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_irq(rx_irq), .drop_count(drop_count)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (mem_req && mem_we) begin
      wr_cnt++;
      if (mem_addr < 32'h80 && mem_addr[4:0] == 5'd8) t_w2 = cyc;
      if (mem_addr < 32'h80 && mem_addr[4:0] == 5'd4) t_w1 = cyc;
    end
    if (rx_irq) begin
      irq_cnt++;
      t_irq = cyc;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cw1(input logic eor, input logic [3:0] proto,
                                      input logic ipf, input logic l4f,
                                      input logic [15:0] len);
    return {1'b1, eor, 1'b1, 1'b1, 6'b0, proto, ipf, l4f, len};
  endfunction

  function automatic logic [31:0] cw2(input logic [2:0] port, input logic crc,
                                      input logic [1:0] vt);
    return {20'b0, crc, port, 6'b0, vt};
  endfunction

  task automatic prep_desc(input int i, input logic [15:0] size, input logic eor);
    mem[i*8]   = 32'h100 + 32'(i) * 32'h40;
    mem[i*8+1] = {1'b0, eor, 1'b1, 1'b1, 12'b0, size};
    mem[i*8+2] = 32'h0;
    mem[64 + i*16 + 8] = 32'hC0FF_EE00 | 32'(i);
  endtask

  task automatic send_frame(input int nw, input logic [3:0] lastkeep,
                            input logic [2:0] port, input logic [3:0] proto,
                            input logic l4f, input logic ipf, input logic [1:0] vt,
                            input logic crc, input logic [31:0] seed);
    s_src_port = port; s_proto = proto; s_l4_fail = l4f; s_ip_fail = ipf;
    s_vtag = vt; s_crc_err = crc;
    for (int k = 0; k < nw; k++) begin
      s_tvalid = 1'b1;
      s_tdata  = seed + 32'(k);
      s_tlast  = (k == nw - 1);
      s_tkeep  = (k == nw - 1) ? lastkeep : 4'hF;
      while (!s_tready) @(negedge clk);
      @(negedge clk);
    end
    s_tvalid = 1'b0; s_tlast = 1'b0; s_tkeep = 4'hF;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_data(input string req, input int i, input int nwords,
                            input logic [31:0] seed);
    for (int k = 0; k < nwords; k++)
      chk(req, $sformatf("desc%0d data word %0d", i, k), mem[64 + i*16 + k], seed + 32'(k));
  endtask

  task automatic t_reset;
    chk("R1", "tready in reset", {31'b0, s_tready}, 32'd0);
    chk("R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
    chk("R1", "irq in reset", {31'b0, rx_irq}, 32'd0);
    chk("R1", "drop_count in reset", {16'b0, drop_count}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "mem_req idle", {31'b0, mem_req}, 32'd0);
    chk("R1", "tready idle", {31'b0, s_tready}, 32'd0);
  endtask

  task automatic t_basic;
    send_frame(5, 4'b0011, 3'd1, 4'd5, 1'b0, 1'b1, 2'b01, 1'b0, 32'hA000_0000);
    check_data("R2", 0, 5, 32'hA000_0000);
    chk("R3", "desc0 cw1", mem[1], cw1(1'b0, 4'd5, 1'b1, 1'b0, 16'd18));
    chk("R4", "desc0 cw2", mem[2], cw2(3'd1, 1'b0, 2'b01));
    chk("R5", "cw2 cycle before cw1", 32'(t_w2), 32'(t_w1 - 1));
    chk("R5", "irq cycle after cw1", 32'(t_irq), 32'(t_w1 + 1));
    chk("R5", "irq count", 32'(irq_cnt), 32'd1);
  endtask

  task automatic t_port_crc;
    send_frame(3, 4'hF, 3'd4, 4'd13, 1'b1, 1'b0, 2'b10, 1'b1, 32'hB000_0000);
    check_data("R7", 1, 3, 32'hB000_0000);
    chk("R3", "desc1 cw1", mem[9], cw1(1'b0, 4'd13, 1'b0, 1'b1, 16'd12));
    chk("R12", "desc1 cw2 crc", mem[10], cw2(3'd4, 1'b1, 2'b10));
    chk("R5", "irq count", 32'(irq_cnt), 32'd2);
  endtask

  task automatic t_masked;
    irq_mask = 1'b1;
    send_frame(2, 4'hF, 3'd0, 4'd2, 1'b0, 1'b0, 2'b00, 1'b0, 32'hC000_0000);
    irq_mask = 1'b0;
    chk("R6", "irq suppressed", 32'(irq_cnt), 32'd2);
    chk("R6", "desc2 cw1 written", mem[17], cw1(1'b0, 4'd2, 1'b0, 1'b0, 16'd8));
    check_data("R6", 2, 2, 32'hC000_0000);
  endtask

  task automatic t_trunc;
    send_frame(12, 4'hF, 3'd2, 4'd1, 1'b0, 1'b0, 2'b00, 1'b0, 32'hD000_0000);
    check_data("R9", 3, 8, 32'hD000_0000);
    chk("R9", "canary beyond buffer", mem[64 + 48 + 8], 32'hC0FF_EE03);
    chk("R9", "desc3 cw1 len capped, eor kept", mem[25], cw1(1'b1, 4'd1, 1'b0, 1'b0, 16'd32));
    chk("R9", "desc3 cw2 crc on truncation", mem[26], cw2(3'd2, 1'b1, 2'b00));
  endtask

  task automatic t_drop;
    logic [31:0] saved;
    int w0, i0;
    saved = mem[1]; w0 = wr_cnt; i0 = irq_cnt;
    send_frame(4, 4'hF, 3'd1, 4'd5, 1'b0, 1'b0, 2'b00, 1'b0, 32'hE000_0000);
    chk("R8", "drop_count", {16'b0, drop_count}, 32'd1);
    chk("R8", "no memory write", 32'(wr_cnt), 32'(w0));
    chk("R8", "no irq", 32'(irq_cnt), 32'(i0));
    chk("R8", "desc0 untouched", mem[1], saved);
  endtask

  task automatic t_wrap;
    prep_desc(0, 16'd32, 1'b0);
    send_frame(2, 4'b0111, 3'd0, 4'd6, 1'b0, 1'b0, 2'b00, 1'b0, 32'hF000_0000);
    chk("R7", "wrapped into desc0", mem[1], cw1(1'b0, 4'd6, 1'b0, 1'b0, 16'd7));
    check_data("R7", 0, 2, 32'hF000_0000);
    chk("R8", "drop_count unchanged", {16'b0, drop_count}, 32'd1);
  endtask

  task automatic t_suspend;
    int bad;
    prep_desc(1, 16'd32, 1'b0);
    bad = 0;
    ctl_suspend = 1'b1;
    s_tvalid = 1'b1; s_tdata = 32'h1111_0000; s_tlast = 1'b0;
    repeat (16) begin
      @(negedge clk);
      if (s_tready || mem_req) bad++;
    end
    ctl_suspend = 1'b0; ctl_poll_en = 1'b0;
    repeat (16) begin
      @(negedge clk);
      if (s_tready || mem_req) bad++;
    end
    chk("R10", "no claim while stopped", 32'(bad), 32'd0);
    chk("R10", "desc1 still hardware owned", {31'b0, mem[9][31]}, 32'd0);
    ctl_poll_en = 1'b1;
    send_frame(2, 4'hF, 3'd3, 4'd14, 1'b0, 1'b0, 2'b11, 1'b0, 32'h1111_0000);
    chk("R10", "held frame stored", mem[9], cw1(1'b0, 4'd14, 1'b0, 1'b0, 16'd8));
    chk("R4", "desc1 cw2", mem[10], cw2(3'd3, 1'b0, 2'b11));
  endtask

  task automatic t_clear;
    logic [31:0] saved2;
    saved2 = mem[17];
    prep_desc(0, 16'd32, 1'b0);
    ctl_clr_state = 1'b1;
    @(negedge clk);
    ctl_clr_state = 1'b0;
    @(negedge clk);
    send_frame(1, 4'hF, 3'd1, 4'd2, 1'b0, 1'b0, 2'b00, 1'b0, 32'h2222_0000);
    chk("R11", "frame placed at base", mem[1], cw1(1'b0, 4'd2, 1'b0, 1'b0, 16'd4));
    chk("R11", "desc2 untouched", mem[17], saved2);
    chk("R11", "drop_count unchanged", {16'b0, drop_count}, 32'd1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 4; i++) prep_desc(i, 16'd32, i == 3);
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_port_crc();
    t_masked();
    t_trunc();
    t_drop();
    t_wrap();
    t_suspend();
    t_clear();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule